// File: doc/BRIEF.md
# Streaming CRC32C Copy-and-Check Unit

This unit sits in the data path of a memory-copy engine. A command sets the payload length, the operating mode and the options for the checksum. The payload then arrives one byte per cycle on a valid/ready input stream. While it arrives, the unit folds each byte into a CRC32C (Castagnoli) checksum. In copy mode it also passes each byte to a valid/ready output stream. In check-only mode it consumes the bytes and forwards nothing. When the payload ends, the unit can store the checksum or test it against an expected value. The expected value can come with the command, or it can be the four bytes that trail the payload inline. In the same way, the stored checksum can leave on a result port or as four bytes appended to the output stream.

Back-pressure rules: a byte moves on either stream only in a cycle where valid and ready are both high. A source must hold valid, and keep its data stable, until the byte is taken. In copy mode the payload passes through combinationally, so `in_ready` follows `out_ready` and `out_valid` follows `in_valid`. In check-only mode, and while trailing expected bytes are collected, `in_ready` stays high. While appended result bytes are sent, the unit holds `out_valid` high and `out_data` stable until `out_ready` takes each byte. A command is taken only when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while the unit is idle.

Top module: `crcx_stream_unit`

## Requirements
- R1: The checksum is CRC32C. It uses the reflected polynomial 0x82F63B78, starts from 0xFFFFFFFF and is inverted at the end. For the nine ASCII bytes "123456789" the checksum value is 0xE3069283.
- R2: When `cmd_seed_en` is high, `cmd_seed` replaces 0xFFFFFFFF as the start value of the CRC register.
- R3: A command with both store and test set is rejected. Within two cycles, `done` and `cmd_bad` go high. No input byte is taken, no output byte is sent, and `err` stays low.
- R4: A command with inline set but neither store nor test set is rejected in the same way as R3.
- R5: In test mode, when the final checksum differs from the expected value, `err` is high at `done`. When the two match, `err` stays low. Without inline, the expected value is `cmd_expect`, given as a plain checksum value.
- R6: In store mode without inline, `res_crc` carries the checksum in wire byte order. `res_crc[31:24]` is bits 7:0 of the checksum, and so on down to `res_crc[7:0]`, which is bits 31:24. In every other case `res_crc` reads zero at `done`.
- R7: In copy mode every payload byte appears on the output stream, in order. In check-only mode no payload byte is sent.
- R8: With inline and test set, the unit takes four extra input bytes after the payload as the expected value. The first of these bytes is bits 7:0. These bytes are not folded into the checksum and are never forwarded.
- R9: In copy mode with inline and store set, four result bytes follow the payload on the output stream, least significant byte first.
- R10: In check-only mode with inline and store set, only the four result bytes appear on the output stream. They are meant for the location that trails the source data.
- R11: After reset, `cmd_ready` is high and `done` and `err` are low. `done`, `err` and `cmd_bad` stay as set until the next command is taken, and they read low in the cycle after it is taken.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit is idle and takes a command |
| cmd_len | input | LEN_W | Payload length in bytes (zero allowed) |
| cmd_copy | input | 1 | 1: forward the payload; 0: check-only |
| cmd_store | input | 1 | Store mode |
| cmd_test | input | 1 | Test mode |
| cmd_inline | input | 1 | Expected value or result travels in the trailing four bytes |
| cmd_seed_en | input | 1 | Use `cmd_seed` as the start value |
| cmd_seed | input | 32 | Start value of the CRC register |
| cmd_expect | input | 32 | Expected checksum for test mode without inline |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte taken this cycle when valid |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes the output byte |
| out_data | output | 8 | Output byte |
| done | output | 1 | Command finished; held until the next command is taken |
| err | output | 1 | Checksum mismatch; held until the next command is taken |
| cmd_bad | output | 1 | Last command was rejected; held until the next command is taken |
| res_crc | output | 32 | Stored checksum in wire byte order |

## Verification
The CRC register and the byte counter are never visible directly. If the CRC register is wrong at any point, `res_crc`, the appended bytes or `err` show it at the next `done`, so every store and test command against a model checksum exposes it. If the count or the phase sequencing is wrong, the output stream has the wrong number of bytes, or an input byte is taken or left behind. Both show up within the same command. Corrupt trailing bytes and corrupt expected values make the compare visible in both directions.

// File: rtl/crcx_pkg.sv
package crcx_pkg;
  localparam logic [31:0] CRCX_POLY = 32'h82F63B78;
  localparam logic [31:0] CRCX_INIT = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DATA = 3'd1,
    PH_TIN  = 3'd2,
    PH_TOUT = 3'd3,
    PH_FIN  = 3'd4
  } phase_t;

  // Fold one byte into a reflected CRC register, LSB first.
  function automatic logic [31:0] crc_fold(input logic [31:0] c,
                                           input logic [7:0]  b,
                                           input logic [31:0] poly);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction

  // Checksum value to wire order: low byte first in the top lane.
  function automatic logic [31:0] to_wire(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/crcx_engine.sv
module crcx_engine #(
  parameter logic [31:0] POLY = crcx_pkg::CRCX_POLY
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] seed,
  input  logic        step,
  input  logic [7:0]  din,
  output logic [31:0] crc_fin
);
  logic [31:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '0;
    else if (load) crc_q <= seed;
    else if (step) crc_q <= crcx_pkg::crc_fold(crc_q, din, POLY);
  end

  assign crc_fin = ~crc_q;
endmodule

// File: rtl/crcx_tail.sv
module crcx_tail #(
  parameter int TAIL_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      shift,
  input  logic [7:0]                din,
  input  logic [$clog2(TAIL_BYTES)-1:0] sel,
  input  logic [8*TAIL_BYTES-1:0]   value,
  output logic [8*TAIL_BYTES-1:0]   exp_q,
  output logic [7:0]                byte_o
);
  localparam int TW = 8 * TAIL_BYTES;

  // First byte received ends up as the least significant byte.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     exp_q <= '0;
    else if (clr)   exp_q <= '0;
    else if (shift) exp_q <= {din, exp_q[TW-1:8]};
  end

  logic [7:0] lanes [TAIL_BYTES];
  for (genvar g = 0; g < TAIL_BYTES; g++) begin : g_lane
    assign lanes[g] = value[8*g +: 8];
  end
  assign byte_o = lanes[sel];
endmodule

// File: rtl/crcx_ctrl.sv
module crcx_ctrl
  import crcx_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int TAIL_BYTES = 4,
  localparam int IW        = $clog2(TAIL_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_copy,
  input  logic             cmd_store,
  input  logic             cmd_test,
  input  logic             cmd_inline,
  input  logic [31:0]      cmd_expect,
  input  logic             in_fire,
  input  logic             out_fire,
  input  logic [31:0]      crc_fin,
  input  logic [31:0]      tail_exp,
  output logic             cmd_ready,
  output logic             accept,
  output phase_t           ph,
  output logic             copy_q,
  output logic [IW-1:0]    idx_q,
  output logic             done,
  output logic             err,
  output logic             cmd_bad,
  output logic [31:0]      res_crc
);
  localparam logic [IW-1:0] IDX_LAST = IW'(TAIL_BYTES - 1);

  phase_t           ph_n;
  logic [LEN_W-1:0] cnt_q;
  logic             store_q, test_q, inl_q, bad_q;
  logic [31:0]      oob_q;
  logic             cmd_is_bad;
  phase_t           after_data_cmd, after_data_reg;

  assign cmd_ready  = (ph == PH_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign cmd_is_bad = (cmd_store && cmd_test) || (cmd_inline && !cmd_store && !cmd_test);

  // Phase after the payload, from the command fields or the held copy.
  always_comb begin
    after_data_cmd = PH_FIN;
    if (cmd_inline && cmd_test)       after_data_cmd = PH_TIN;
    else if (cmd_inline && cmd_store) after_data_cmd = PH_TOUT;
    after_data_reg = PH_FIN;
    if (inl_q && test_q)              after_data_reg = PH_TIN;
    else if (inl_q && store_q)        after_data_reg = PH_TOUT;
  end

  always_comb begin
    ph_n = ph;
    unique case (ph)
      PH_IDLE: if (accept) begin
        if (cmd_is_bad)          ph_n = PH_FIN;
        else if (cmd_len != '0)  ph_n = PH_DATA;
        else                     ph_n = after_data_cmd;
      end
      PH_DATA: if (in_fire && cnt_q == LEN_W'(1)) ph_n = after_data_reg;
      PH_TIN:  if (in_fire && idx_q == IDX_LAST)  ph_n = PH_FIN;
      PH_TOUT: if (out_fire && idx_q == IDX_LAST) ph_n = PH_FIN;
      PH_FIN:  ph_n = PH_IDLE;
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      copy_q  <= 1'b0;
      store_q <= 1'b0;
      test_q  <= 1'b0;
      inl_q   <= 1'b0;
      bad_q   <= 1'b0;
      oob_q   <= '0;
    end else begin
      ph <= ph_n;
      if (accept) begin
        cnt_q   <= cmd_len;
        idx_q   <= '0;
        copy_q  <= cmd_copy;
        store_q <= cmd_store;
        test_q  <= cmd_test;
        inl_q   <= cmd_inline;
        bad_q   <= cmd_is_bad;
        oob_q   <= cmd_expect;
      end else begin
        if (ph == PH_DATA && in_fire) cnt_q <= cnt_q - LEN_W'(1);
        if ((ph == PH_TIN && in_fire) || (ph == PH_TOUT && out_fire))
          idx_q <= idx_q + IW'(1);
      end
    end
  end

  // Completion flags: set in the finish phase, cleared on the next command.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      err     <= 1'b0;
      cmd_bad <= 1'b0;
      res_crc <= '0;
    end else if (accept) begin
      done    <= 1'b0;
      err     <= 1'b0;
      cmd_bad <= 1'b0;
      res_crc <= '0;
    end else if (ph == PH_FIN) begin
      done    <= 1'b1;
      cmd_bad <= bad_q;
      err     <= !bad_q && test_q && (crc_fin != (inl_q ? tail_exp : oob_q));
      res_crc <= (!bad_q && store_q && !inl_q) ? to_wire(crc_fin) : '0;
    end
  end
endmodule

// File: rtl/crcx_stream_unit.sv
module crcx_stream_unit
  import crcx_pkg::*;
#(
  parameter int          LEN_W      = 16,
  parameter int          TAIL_BYTES = 4,
  parameter logic [31:0] POLY       = CRCX_POLY,
  parameter logic [31:0] INIT       = CRCX_INIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_copy,
  input  logic             cmd_store,
  input  logic             cmd_test,
  input  logic             cmd_inline,
  input  logic             cmd_seed_en,
  input  logic [31:0]      cmd_seed,
  input  logic [31:0]      cmd_expect,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             done,
  output logic             err,
  output logic             cmd_bad,
  output logic [31:0]      res_crc
);
  localparam int IW = $clog2(TAIL_BYTES);

  phase_t        ph;
  logic          accept, copy_q, in_fire, out_fire;
  logic [IW-1:0] idx_q;
  logic [31:0]   crc_fin, tail_exp;
  logic [7:0]    tail_byte;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = in_data;
    unique case (ph)
      PH_DATA: begin
        in_ready  = copy_q ? out_ready : 1'b1;
        out_valid = copy_q && in_valid;
      end
      PH_TIN:  in_ready = 1'b1;
      PH_TOUT: begin
        out_valid = 1'b1;
        out_data  = tail_byte;
      end
      default: ;
    endcase
  end

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  crcx_ctrl #(.LEN_W(LEN_W), .TAIL_BYTES(TAIL_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_len(cmd_len), .cmd_copy(cmd_copy),
    .cmd_store(cmd_store), .cmd_test(cmd_test), .cmd_inline(cmd_inline),
    .cmd_expect(cmd_expect), .in_fire(in_fire), .out_fire(out_fire),
    .crc_fin(crc_fin), .tail_exp(tail_exp), .cmd_ready(cmd_ready),
    .accept(accept), .ph(ph), .copy_q(copy_q), .idx_q(idx_q),
    .done(done), .err(err), .cmd_bad(cmd_bad), .res_crc(res_crc)
  );

  crcx_engine #(.POLY(POLY)) u_engine (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .seed(cmd_seed_en ? cmd_seed : INIT),
    .step(ph == PH_DATA && in_fire), .din(in_data), .crc_fin(crc_fin)
  );

  crcx_tail #(.TAIL_BYTES(TAIL_BYTES)) u_tail (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .shift(ph == PH_TIN && in_fire), .din(in_data),
    .sel(idx_q), .value(crc_fin), .exp_q(tail_exp), .byte_o(tail_byte)
  );
endmodule

// File: rtl/crcx_stream_chk.sv
module crcx_stream_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       cmd_store,
  input logic       cmd_test,
  input logic       cmd_inline,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       done,
  input logic       err,
  input logic       cmd_bad
);
  // R3
  both_modes_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_store && cmd_test)
      |=> (!in_ready && !out_valid) ##1 (done && cmd_bad && !err));

  // R4
  lone_inline_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_inline && !cmd_store && !cmd_test)
      |=> (!in_ready && !out_valid) ##1 (done && cmd_bad && !err));

  // R5
  err_only_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !cmd_bad);

  // R11
  busy_flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> (!done && !err && !cmd_bad));

  // R11
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!done && !err && !cmd_bad));

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind crcx_stream_unit crcx_stream_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_store(cmd_store), .cmd_test(cmd_test), .cmd_inline(cmd_inline),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .done(done), .err(err), .cmd_bad(cmd_bad)
);

// File: tb/crcx_stream_unit_test.sv
`timescale 1ns/1ps
module crcx_stream_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cmd_valid = 0, cmd_ready, cmd_copy = 0, cmd_store = 0, cmd_test = 0;
  logic        cmd_inline = 0, cmd_seed_en = 0;
  logic [15:0] cmd_len = 0;
  logic [31:0] cmd_seed = 0, cmd_expect = 0, res_crc;
  logic        in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [7:0]  in_data = 0, out_data;
  logic        done, err, cmd_bad;

  crcx_stream_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_len(cmd_len), .cmd_copy(cmd_copy), .cmd_store(cmd_store),
    .cmd_test(cmd_test), .cmd_inline(cmd_inline), .cmd_seed_en(cmd_seed_en),
    .cmd_seed(cmd_seed), .cmd_expect(cmd_expect), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .done(done), .err(err),
    .cmd_bad(cmd_bad), .res_crc(res_crc)
  );

  int n_checks = 0, n_errors = 0;
  logic [7:0] pay [0:63];
  int plen;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bitwise reference of the checksum, from the requirement text (R1).
  function automatic logic [31:0] ref_crc(input logic [31:0] start, input int n);
    logic [31:0] c = start;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ pay[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'h82F63B78;
      end
    end
    return ~c;
  endfunction

  function automatic logic [31:0] wire_of(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // One command end to end; returns the final checksum of the model.
  task automatic run_txn(input bit cp, input bit st, input bit ts, input bit il,
                         input bit se, input logic [31:0] sd, input bit corrupt,
                         output logic [31:0] f);
    logic [7:0] fb [0:71];
    logic [7:0] eb [0:71];
    logic [7:0] got [0:71];
    int total, en, gn, fi, cyc;
    bit bad, held, pend;
    logic [7:0] pend_d;
    bad = (st && ts) || (il && !st && !ts);
    f = ref_crc(se ? sd : 32'hFFFFFFFF, plen);
    total = 0; en = 0;
    for (int i = 0; i < plen; i++) begin
      fb[total] = pay[i]; total++;
      if (cp) begin eb[en] = pay[i]; en++; end
    end
    if (il && ts) for (int k = 0; k < 4; k++) begin
      fb[total] = f[8*k +: 8] ^ ((corrupt && k == 0) ? 8'h5A : 8'h00); total++;
    end
    if (il && st && !bad) for (int k = 0; k < 4; k++) begin
      eb[en] = f[8*k +: 8]; en++;
    end
    if (bad) en = 0;
    @(posedge clk); #1;
    cmd_valid = 1; cmd_len = 16'(plen); cmd_copy = cp; cmd_store = st; cmd_test = ts;
    cmd_inline = il; cmd_seed_en = se; cmd_seed = sd;
    cmd_expect = corrupt ? (f ^ 32'h0000_0100) : f;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R11 idle ready", 32'(cmd_ready), 1);
    @(posedge clk); #1;
    cmd_valid = 0;
    @(negedge clk);
    chk(!done && !err && !cmd_bad, "R11 flags clear after accept",
        {29'd0, done, err, cmd_bad}, 0);
    @(posedge clk); #1;
    gn = 0; fi = 0; held = 0; pend = 0; cyc = 0;
    forever begin
      if (!held) in_valid = (fi < total) && ($urandom % 4 != 0);
      in_data = fb[fi];
      out_ready = ($urandom % 3 != 0);
      @(negedge clk);
      if (pend) begin
        chk(out_valid && out_data == pend_d, "R12 output held",
            {23'd0, out_valid, out_data}, {23'd1, 1'b1, pend_d});
      end
      if (done || cyc > 2000) break;
      if (in_valid && in_ready) begin fi++; held = 0; end else held = in_valid;
      pend = out_valid && !out_ready; pend_d = out_data;
      if (out_valid && out_ready && gn < 72) begin got[gn] = out_data; gn++; end
      cyc++;
      @(posedge clk); #1;
    end
    chk(done == 1'b1, "R11 done", 32'(done), 1);
    chk(cmd_bad == bad, bad ? "R3/R4 reject" : "R3 accepted ok", 32'(cmd_bad), 32'(bad));
    chk(err == (!bad && ts && corrupt), "R5/R8 err", 32'(err), 32'(!bad && ts && corrupt));
    chk(res_crc == ((!bad && st && !il) ? wire_of(f) : 32'd0), "R6 res_crc",
        res_crc, (!bad && st && !il) ? wire_of(f) : 32'd0);
    chk(fi == (bad ? 0 : total), "R8 input bytes taken", 32'(fi), 32'(bad ? 0 : total));
    chk(gn == en, "R7/R9/R10 output count", 32'(gn), 32'(en));
    for (int i = 0; i < gn && i < en; i++)
      if (got[i] != eb[i]) chk(0, "R7/R9/R10 output byte", {24'd0, got[i]}, {24'd0, eb[i]});
    @(posedge clk); #1;
    in_valid = 0; out_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] f;
    string s;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(cmd_ready && !done && !err && !out_valid && !in_ready, "R11 reset state",
        {27'd0, cmd_ready, done, err, out_valid, in_ready}, 32'h10);
    rst_n = 1;

    // R1, R6, R7: known vector, copy + store out of band
    s = "123456789";
    plen = 9;
    for (int i = 0; i < 9; i++) pay[i] = s[i];
    run_txn(1, 1, 0, 0, 0, 0, 0, f);
    chk(f == 32'hE3069283, "R1 model vector", f, 32'hE3069283);
    chk(res_crc == 32'h839206E3, "R1 known checksum", res_crc, 32'h839206E3);

    // R2: seeded start
    run_txn(0, 1, 0, 0, 1, 32'h1234_5678, 0, f);
    chk(res_crc != 32'h839206E3, "R2 seed changes result", res_crc, 32'h839206E3);

    // R5 / R11: mismatch, then err sticky while idle
    run_txn(0, 0, 1, 0, 0, 0, 1, f);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(err && done, "R11 err sticky", {30'd0, err, done}, 3);

    // R8 inline test pass/fail, R9 and R10 inline store
    run_txn(1, 0, 1, 1, 0, 0, 0, f);
    run_txn(1, 0, 1, 1, 0, 0, 1, f);
    run_txn(1, 1, 0, 1, 0, 0, 0, f);
    run_txn(0, 1, 0, 1, 1, 32'hDEAD_BEEF, 0, f);

    // R3, R4: invalid commands
    run_txn(1, 1, 1, 0, 0, 0, 0, f);
    run_txn(1, 0, 0, 1, 0, 0, 0, f);

    // zero-length payloads
    plen = 0;
    run_txn(1, 1, 0, 1, 0, 0, 0, f);
    run_txn(0, 0, 1, 1, 0, 0, 0, f);

    // constrained random mix
    for (int t = 0; t < 60; t++) begin
      bit cp, st, ts, il, se, co;
      int m;
      plen = $urandom % 24;
      for (int i = 0; i < plen; i++) pay[i] = 8'($urandom);
      cp = $urandom % 2; se = $urandom % 2; co = $urandom % 2;
      m = $urandom % 7;
      st = (m == 0 || m == 1 || m == 5);
      ts = (m == 2 || m == 3 || m == 5);
      il = (m == 1 || m == 3 || m == 6);
      run_txn(cp, st, ts, il, se, $urandom, co, f);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule